// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block chooses which of four DMA channels may use the shared transfer engine next. Each channel raises its own request line. The arbiter picks one channel, drives a one-hot grant with a valid flag, and keeps that grant until the engine signals completion with a one-cycle done pulse. Only after that pulse does it make the next decision.

An 8-bit control register is written and read through a simple port. It holds three things. The first is a master enable. The second is a bit that selects between fixed priority and rotating priority, and software may change it while the block runs. The third is one FIFO-use enable per channel. The arbiter does not use the FIFO-use enables itself; it only stores them and passes them on to the channel datapaths.

When the master enable is clear, all arbitration state is held cleared. That includes any grant in progress and the rotation pointer.

Top module: `dma_chan_arbiter`

## Requirements
- R1: While the enable (control bit 0) is 0, `gnt_valid` stays 0 and requests are ignored.
- R2: In fixed mode (control bit 1 = 0), the lowest-numbered requesting channel wins, so channel 0 beats 1, 1 beats 2, and 2 beats 3.
- R3: In rotating mode (control bit 1 = 1), the search starts at the channel one above the most recently granted channel and wraps from 3 to 0. The last-served channel therefore ranks lowest.
- R4: Whenever rotating mode is entered from fixed mode, the pointer acts as if channel 3 was served last, so channel 0 ranks highest.
- R5: After reset, `gnt` = 0, `gnt_valid` = 0, `reg_rdata` = 0 and `fifo_en` = 0.
- R6: `reg_rdata` returns the enable in bit 0, the mode in bit 1 and the FIFO-use enables in bits 6:3. Bits 2 and 7 read 0 whatever was written to them.
- R7: `fifo_en[n]` equals control bit 3+n.
- R8: Whenever `gnt_valid` is 1, `gnt` is one-hot. When `gnt_valid` is 0, `gnt` is 0. A grant stays unchanged until the clock edge that samples `done` high. The channel is then released, and a new grant can appear one cycle later.
- R9: When no channel requests, `gnt_valid` stays 0 and the rotation pointer does not move. A `done` pulse while idle has no effect.
- R10: A write that clears the enable drops any grant on that same clock edge. It also returns the rotation pointer to "channel 3 served last".

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| req | input | 4 | Per-channel request lines |
| done | input | 1 | Pulse marking the end of the granted transfer |
| gnt | output | 4 | One-hot grant |
| gnt_valid | output | 1 | A grant is active |
| fifo_en | output | 4 | Per-channel FIFO-use enables |

## Verification
The bench targets the rotation wrap from channel 3 back to 0. A design that wrapped wrongly would skip or repeat a channel. It also drops a request while its grant is held and raises a higher-priority one; an arbiter that re-decided early would move the grant. Three further checks cover idle `done` pulses, which would disturb the pointer if they were counted, and two resets of the pointer: leaving and re-entering rotating mode, and clearing the enable in the middle of a grant. A design that kept the stale pointer in either case would grant the wrong channel afterwards. The reserved bits are written as 1 and read back, to catch a register that stores them.

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter #(
  parameter int NCH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [NCH+3:0]   reg_wdata,
  output logic [NCH+3:0]   reg_rdata,
  input  logic [NCH-1:0]   req,
  input  logic             done,
  output logic [NCH-1:0]   gnt,
  output logic             gnt_valid,
  output logic [NCH-1:0]   fifo_en
);
  localparam int IDXW = $clog2(NCH);
  localparam logic [IDXW-1:0] LAST_CH = IDXW'(NCH - 1);

  logic             en_q, rr_q, busy_q;
  logic [NCH-1:0]   fifo_q, win;
  logic [IDXW-1:0]  last_q, win_idx, idx;
  logic             found, clr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q   <= 1'b0;
      rr_q   <= 1'b0;
      fifo_q <= '0;
    end else if (reg_we) begin
      en_q   <= reg_wdata[0];
      rr_q   <= reg_wdata[1];
      fifo_q <= reg_wdata[3 +: NCH];
    end

  assign reg_rdata = {1'b0, fifo_q, 1'b0, rr_q, en_q};
  assign fifo_en   = fifo_q;
  assign clr       = !en_q || (reg_we && !reg_wdata[0]);

  always_comb begin
    win     = '0;
    win_idx = '0;
    found   = 1'b0;
    idx     = '0;
    for (int k = 0; k < NCH; k++) begin
      idx = rr_q ? IDXW'(last_q + IDXW'(k + 1)) : IDXW'(k);
      if (!found && req[idx]) begin
        found    = 1'b1;
        win[idx] = 1'b1;
        win_idx  = idx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy_q <= 1'b0;
      gnt    <= '0;
      last_q <= LAST_CH;
    end else if (clr) begin
      busy_q <= 1'b0;
      gnt    <= '0;
      last_q <= LAST_CH;
    end else begin
      if (!rr_q) last_q <= LAST_CH;
      if (busy_q) begin
        if (done) begin
          busy_q <= 1'b0;
          gnt    <= '0;
        end
      end else if (found) begin
        busy_q <= 1'b1;
        gnt    <= win;
        if (rr_q) last_q <= win_idx;
      end
    end

  assign gnt_valid = busy_q;

  assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> $countones(gnt) == 1);

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_valid |-> gnt == '0);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !done && en_q && !(reg_we && !reg_wdata[0])) |=> (gnt_valid && $stable(gnt)));

  assert_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !gnt_valid);

  assert_requested_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_valid) |-> (gnt & $past(req)) != '0);

  assert_fixed_prio_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gnt_valid) && !rr_q && !$past(reg_we)) |-> ((gnt - 1'b1) & $past(req)) == '0);
endmodule

// File: tb/test_dma_chan_arbiter.sv
`timescale 1ns/100ps
module test_dma_chan_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [3:0] req = '0;
  logic       done = 1'b0;
  logic [3:0] gnt;
  logic       gnt_valid;
  logic [3:0] fifo_en;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  dma_chan_arbiter #(.NCH(4)) i_dma_chan_arbiter (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .req(req), .done(done), .gnt(gnt),
    .gnt_valid(gnt_valid), .fifo_en(fifo_en)
  );

  // {mode nibble, request nibble, expected grant nibble}
  localparam int NV = 13;
  localparam logic [11:0] VEC [NV] = '{
    12'h0F1, 12'h0E2, 12'h0C4, 12'h088, 12'h0A2,
    12'h1F1, 12'h1F2, 12'h1F4, 12'h1F8, 12'h1F1, 12'h198, 12'h191, 12'h162
  };

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    reg_we = 1'b1;
    reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic run_grant(input logic [3:0] r, input logic [3:0] exp, input string tag);
    @(negedge clk);
    req = r;
    @(negedge clk);
    chk(gnt_valid && gnt == exp, tag, {3'b0, gnt_valid, gnt}, {4'h1, exp});
    req = '0;
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk(!gnt_valid, {tag, " release R8"}, {7'b0, gnt_valid}, 8'h00);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic cur_rr;
    repeat (3) @(negedge clk);
    chk(gnt == 0 && !gnt_valid && reg_rdata == 0 && fifo_en == 0, "R5 reset",
        {gnt, fifo_en}, 8'h00);
    rst_n = 1'b1;

    // R1: disabled block ignores requests
    @(negedge clk);
    req = 4'hF;
    repeat (3) @(negedge clk);
    chk(!gnt_valid, "R1 disabled", {7'b0, gnt_valid}, 8'h00);
    req = '0;

    // R6 / R7: register fields and reserved bits
    wr(8'hFF);
    chk(reg_rdata == 8'h7B, "R6 readback", reg_rdata, 8'h7B);
    chk(fifo_en == 4'hF, "R7 fifo all", {4'h0, fifo_en}, 8'h0F);
    wr(8'h28);
    chk(reg_rdata == 8'h28, "R6 readback2", reg_rdata, 8'h28);
    chk(fifo_en == 4'b0101, "R7 fifo bits", {4'h0, fifo_en}, 8'h05);

    // vector table: R2 fixed, R3 rotating
    wr(8'h01);
    cur_rr = 1'b0;
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][8] != cur_rr) begin
        cur_rr = VEC[i][8];
        wr({6'b0, cur_rr, 1'b1});
      end
      run_grant(VEC[i][7:4], VEC[i][3:0], cur_rr ? "R3 rotate" : "R2 fixed");
    end

    // R8: grant holds across request changes until done
    wr(8'h01);
    @(negedge clk);
    req = 4'b0100;
    @(negedge clk);
    chk(gnt == 4'b0100, "R8 grant", {4'h0, gnt}, 8'h04);
    req = 4'b0001;
    repeat (3) @(negedge clk);
    chk(gnt_valid && gnt == 4'b0100, "R8 hold", {3'b0, gnt_valid, gnt}, 8'h14);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk(!gnt_valid, "R8 released", {7'b0, gnt_valid}, 8'h00);
    @(negedge clk);
    chk(gnt_valid && gnt == 4'b0001, "R8 regrant", {3'b0, gnt_valid, gnt}, 8'h11);
    req = '0;
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;

    // R9: idle done pulses move nothing
    wr(8'h03);
    run_grant(4'hF, 4'b0001, "R9 setup0");
    run_grant(4'hF, 4'b0010, "R9 setup1");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
      chk(!gnt_valid, "R9 idle", {7'b0, gnt_valid}, 8'h00);
    end
    run_grant(4'hF, 4'b0100, "R9 pointer kept");

    // R4: re-entering rotating mode restarts the pointer
    wr(8'h01);
    wr(8'h03);
    run_grant(4'hE, 4'b0010, "R4 reentry");

    // R10: disable mid-grant drops grant and pointer
    @(negedge clk);
    req = 4'hF;
    @(negedge clk);
    chk(gnt == 4'b0100, "R10 pre", {4'h0, gnt}, 8'h04);
    wr(8'h02);
    chk(!gnt_valid && gnt == 0, "R10 drop", {3'b0, gnt_valid, gnt}, 8'h00);
    repeat (2) @(negedge clk);
    chk(!gnt_valid, "R1 off", {7'b0, gnt_valid}, 8'h00);
    wr(8'h03);
    @(negedge clk);
    chk(gnt_valid && gnt == 4'b0001, "R10 pointer", {3'b0, gnt_valid, gnt}, 8'h11);
    req = '0;
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule